// File: doc/BRIEF.md
# Sparse gathered dot-product engine

This block computes a dot product between a 2:4 compressed sparse operand and an ordinary dense operand. In each group of four positions the sparse side keeps only two values, and each kept value comes with a 2-bit position index. The engine uses those indices to pick the two matching entries out of the four dense values that arrive with the group. It multiplies only those two pairs, so each group of four needs two multiplies where a dense unit needs four. Both products go into a wide signed accumulator.

A job begins with a start pulse that carries the number of groups. The engine takes one group on each cycle in which the group-valid input is high. One cycle after it accepts the last group, it raises a single-cycle done pulse, and the result output then holds the finished sum. A clear input stops any job at once and zeroes the sum. The final value is the same as a dense dot product taken over the expanded sparse operand, wrapped to the accumulator width.

Top module: `sparse_dot_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, busy_o and done_o are low and result_o is zero.
- R2: Kept value k is sval_i[8k+7:8k]. It is multiplied by the dense entry whose position is sidx_i[2k+1:2k], where dense entry j is dense_i[8j+7:8j]. All values are signed two's complement.
- R3: The 32-bit accumulator wraps in two's complement on overflow and never saturates.
- R4: A start pulse with a nonzero group_cnt_i zeroes result_o, sets busy_o from the next cycle and latches the group count. It does this even when a job is already running.
- R5: A start pulse with group_cnt_i equal to zero has no effect.
- R6: A running job adds in exactly the number of groups it was started with. A cycle with grp_valid_i low adds nothing. In the cycle after the edge that accepts the last group, done_o is high for that one cycle and busy_o is low.
- R7: After done, result_o holds its value until the next clear or accepted start.
- R8: grp_valid_i is ignored while busy_o is low.
- R9: clear_i zeroes result_o and ends any job without a done pulse. It wins over a start or a group that arrives in the same cycle.
- R10: A group offered in the same cycle as an accepted start is discarded.
- R11: When the two indices differ, the result equals the dense dot product of the expanded sparse operand (zeros at the positions not kept) with the dense operand, summed over all groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a job (ignored when group_cnt_i is 0) |
| group_cnt_i | input | 17 | Number of groups in the job, sampled on start |
| clear_i | input | 1 | Abort the job and zero the accumulator |
| grp_valid_i | input | 1 | A group is present on the data inputs |
| sval_i | input | 16 | Two kept signed 8-bit sparse values |
| sidx_i | input | 4 | Two 2-bit position indices, one per kept value |
| dense_i | input | 32 | Four signed 8-bit dense values |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse after the last group is accepted |
| result_o | output | 32 | Accumulated dot product |

## Verification
Two functions can land on the same edge. One is the clear input. The other is a job step: the last group being accepted or a fresh start. A directed cycle raises clear_i, start_i and grp_valid_i together while the final group of a running job is on the inputs. The bench then expects result_o to be zero, busy_o to be low and no done pulse on the following cycle. A second collision drives a start and a valid group in the same cycle. It is judged by checking that the final sum leaves out the group that arrived with the start.

// File: rtl/sdot_pkg.sv
package sdot_pkg;
    localparam int SD_DW    = 8;
    localparam int SD_AW    = 32;
    localparam int SD_GRP   = 4;
    localparam int SD_KEEP  = 2;
    localparam int SD_CNT_W = 17;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ZERO = 2'd1,
        ACC_ADD  = 2'd2
    } acc_act_e;
endpackage

// File: rtl/sdot_gather.sv
module sdot_gather #(
    parameter int DW    = 8,
    parameter int GRP   = 4,
    parameter int KEEP  = 2,
    parameter int IDX_W = $clog2(GRP)
) (
    input  logic [GRP*DW-1:0]    dense_i,
    input  logic [KEEP*IDX_W-1:0] idx_i,
    output logic [KEEP*DW-1:0]   sel_o
);
    for (genvar k = 0; k < KEEP; k++) begin : g_lane
        always_comb begin
            sel_o[k*DW +: DW] = '0;
            for (int j = 0; j < GRP; j++) begin
                if (idx_i[k*IDX_W +: IDX_W] == IDX_W'(j))
                    sel_o[k*DW +: DW] = dense_i[j*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/sdot_mul_sum.sv
module sdot_mul_sum #(
    parameter int DW    = 8,
    parameter int KEEP  = 2,
    parameter int SUM_W = 2*DW + $clog2(KEEP)
) (
    input  logic [KEEP*DW-1:0]      val_i,
    input  logic [KEEP*DW-1:0]      sel_i,
    output logic signed [SUM_W-1:0] sum_o
);
    localparam int PW = 2*DW;

    logic signed [PW-1:0] prod [KEEP];

    for (genvar k = 0; k < KEEP; k++) begin : g_mul
        assign prod[k] = $signed(val_i[k*DW +: DW]) * $signed(sel_i[k*DW +: DW]);
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < KEEP; k++)
            sum_o = sum_o + {{(SUM_W-PW){prod[k][PW-1]}}, prod[k]};
    end
endmodule

// File: rtl/sdot_ctrl.sv
module sdot_ctrl
    import sdot_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             clear_i,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             busy_o,
    output logic             done_o,
    output acc_act_e         act_o
);
    logic [CNT_W-1:0] remain_q;
    logic             start_go;
    logic             accept;
    logic             last;

    assign start_go = start_i && (cnt_i != '0);
    assign accept   = busy_o && valid_i && !clear_i && !start_go;
    assign last     = accept && (remain_q == CNT_W'(1));

    always_comb begin
        if (clear_i || start_go) act_o = ACC_ZERO;
        else if (accept)         act_o = ACC_ADD;
        else                     act_o = ACC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            remain_q <= '0;
        end else begin
            done_o <= 1'b0;
            if (clear_i) begin
                busy_o   <= 1'b0;
                remain_q <= '0;
            end else if (start_go) begin
                busy_o   <= 1'b1;
                remain_q <= cnt_i;
            end else if (accept) begin
                remain_q <= remain_q - CNT_W'(1);
                if (last) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sparse_dot_engine.sv
module sparse_dot_engine
    import sdot_pkg::*;
#(
    parameter int DW    = SD_DW,
    parameter int AW    = SD_AW,
    parameter int GRP   = SD_GRP,
    parameter int KEEP  = SD_KEEP,
    parameter int CNT_W = SD_CNT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic [CNT_W-1:0]              group_cnt_i,
    input  logic                          clear_i,
    input  logic                          grp_valid_i,
    input  logic [KEEP*DW-1:0]            sval_i,
    input  logic [KEEP*$clog2(GRP)-1:0]   sidx_i,
    input  logic [GRP*DW-1:0]             dense_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [AW-1:0]                 result_o
);
    localparam int IDX_W = $clog2(GRP);
    localparam int SUM_W = 2*DW + $clog2(KEEP);

    logic [KEEP*DW-1:0]      sel;
    logic signed [SUM_W-1:0] grp_sum;
    acc_act_e                act;
    logic [AW-1:0]           acc_q;

    sdot_gather #(.DW(DW), .GRP(GRP), .KEEP(KEEP), .IDX_W(IDX_W)) u_gather (
        .dense_i (dense_i),
        .idx_i   (sidx_i),
        .sel_o   (sel)
    );

    sdot_mul_sum #(.DW(DW), .KEEP(KEEP), .SUM_W(SUM_W)) u_mul (
        .val_i (sval_i),
        .sel_i (sel),
        .sum_o (grp_sum)
    );

    sdot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .clear_i (clear_i),
        .valid_i (grp_valid_i),
        .cnt_i   (group_cnt_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .act_o   (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (act)
                ACC_ZERO: acc_q <= '0;
                ACC_ADD:  acc_q <= acc_q + {{(AW-SUM_W){grp_sum[SUM_W-1]}}, grp_sum};
                default:  acc_q <= acc_q;
            endcase
        end
    end

    assign result_o = acc_q;
endmodule

// File: rtl/sdot_checker.sv
module sdot_checker #(
    parameter int AW    = 32,
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] group_cnt_i,
    input logic             clear_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [AW-1:0]    result_o
);
    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: done only appears as the job ends
    p_done_ends_job_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $fell(busy_o));

    // R9: clear zeroes the sum and stops the job with no done
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (result_o == '0) && !busy_o && !done_o);

    // R4: an accepted start zeroes the sum and begins a job
    p_start_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !clear_i && group_cnt_i != '0) |=> (result_o == '0) && busy_o);

    // R8: nothing moves the sum while idle
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i && !clear_i) |=> $stable(result_o));
endmodule

bind sparse_dot_engine sdot_checker #(.AW(AW), .CNT_W(CNT_W)) u_sdot_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .group_cnt_i (group_cnt_i),
    .clear_i     (clear_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o)
);

// File: tb/sparse_dot_engine_bench.sv
module sparse_dot_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [16:0] group_cnt_i = '0;
    logic        clear_i = 1'b0;
    logic        grp_valid_i = 1'b0;
    logic [15:0] sval_i = '0;
    logic [3:0]  sidx_i = '0;
    logic [31:0] dense_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [31:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    int seed_v;

    always #2 clk = ~clk;

    sparse_dot_engine u_sparse_dot_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .group_cnt_i(group_cnt_i),
        .clear_i(clear_i), .grp_valid_i(grp_valid_i), .sval_i(sval_i),
        .sidx_i(sidx_i), .dense_i(dense_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int s32(input longint v);
        return int'(v[31:0]);
    endfunction

    // expected contribution of one group from the expanded dense view
    function automatic longint grp_model(input logic [15:0] sv, input logic [3:0] si,
                                         input logic [31:0] dv);
        longint e [4];
        longint s = 0;
        for (int j = 0; j < 4; j++) e[j] = 0;
        e[si[1:0]] = longint'($signed(sv[7:0]));
        e[si[3:2]] = longint'($signed(sv[15:8]));
        for (int j = 0; j < 4; j++) s += e[j] * longint'($signed(dv[8*j +: 8]));
        return s;
    endfunction

    task automatic rand_group();
        logic [1:0] a, b;
        a = 2'($urandom());
        b = 2'($urandom());
        if (b == a) b = a + 2'd1;
        sidx_i  = {b, a};
        sval_i  = 16'($urandom());
        dense_i = $urandom();
    endtask

    task automatic begin_job(input int n);
        start_i = 1'b1; group_cnt_i = 17'(n); grp_valid_i = 1'b1;
        rand_group();   // offered with start: must be discarded (R10)
        cycle();
        start_i = 1'b0; grp_valid_i = 1'b0;
        chk("R4 start zeroes", result_o, 0);
        chk("R4 busy after start", busy_o, 1);
    endtask

    task automatic run_job(input int n, input int gapmax);
        longint exp = 0;
        begin_job(n);
        for (int g = 0; g < n; g++) begin
            int gaps = (gapmax > 0) ? int'($urandom_range(gapmax, 0)) : 0;
            for (int q = 0; q < gaps; q++) begin
                rand_group(); grp_valid_i = 1'b0;
                cycle();
                chk("R6 no add on idle valid", s32(result_o), s32(exp));
            end
            rand_group(); grp_valid_i = 1'b1;
            exp += grp_model(sval_i, sidx_i, dense_i);
            cycle();
            grp_valid_i = 1'b0;
            if (g < n-1) chk("R6 no early done", done_o, 0);
        end
        chk("R6 done after last group", done_o, 1);
        chk("R6 busy low at done", busy_o, 0);
        chk("R11 dense-equivalent result", s32(result_o), s32(exp));
        cycle();
        chk("R6 done single cycle", done_o, 0);
        chk("R7 result holds", s32(result_o), s32(exp));
    endtask

    task automatic run_all();
        longint exp;
        logic [31:0] held;
        // R1 reset
        repeat (3) cycle();
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 result in reset", result_o, 0);
        rst = 1'b0;
        cycle();
        chk("R1 done after reset", done_o, 0);
        chk("R1 result after reset", result_o, 0);

        // R2 directed: 3*d[1] + (-2)*d[3] = 3*20 - 80 = -20
        begin_job(1);
        sval_i = {8'hFE, 8'd3}; sidx_i = {2'd3, 2'd1};
        dense_i = {8'd40, 8'd30, 8'd20, 8'd10}; grp_valid_i = 1'b1;
        cycle(); grp_valid_i = 1'b0;
        chk("R2 index select", s32(result_o), -20);
        chk("R6 done single group", done_o, 1);

        // R2 reversed index order: -128*d[2] + 127*d[0]
        begin_job(1);
        sval_i = {8'd127, 8'h80}; sidx_i = {2'd0, 2'd2};
        dense_i = {8'd1, 8'hF9, 8'd2, 8'hFD}; grp_valid_i = 1'b1;
        cycle(); grp_valid_i = 1'b0;
        chk("R2 swapped order", s32(result_o), 128*7 + 127*(-3));

        // R11 random jobs
        for (int j = 0; j < 24; j++)
            run_job(int'($urandom_range(8, 1)), (j % 3));

        // R7 hold several cycles, R8 valid while idle ignored
        held = result_o;
        for (int q = 0; q < 4; q++) begin
            rand_group(); grp_valid_i = 1'b1;
            cycle();
        end
        grp_valid_i = 1'b0;
        chk("R8 idle valid ignored", result_o, held);
        chk("R8 still idle", busy_o, 0);

        // R5 zero-count start ignored
        start_i = 1'b1; group_cnt_i = '0;
        cycle(); start_i = 1'b0;
        chk("R5 zero count result", result_o, held);
        chk("R5 zero count busy", busy_o, 0);

        // R10 restart mid-job
        begin_job(3);
        rand_group(); grp_valid_i = 1'b1;
        cycle();
        start_i = 1'b1; group_cnt_i = 17'd2; rand_group();
        cycle();
        start_i = 1'b0;
        chk("R10 restart zero", result_o, 0);
        exp = 0;
        for (int g = 0; g < 2; g++) begin
            rand_group(); grp_valid_i = 1'b1;
            exp += grp_model(sval_i, sidx_i, dense_i);
            cycle();
        end
        grp_valid_i = 1'b0;
        chk("R10 done after restart count", done_o, 1);
        chk("R10 start-cycle group dropped", s32(result_o), s32(exp));

        // R9 clear collides with last group and start
        begin_job(2);
        rand_group(); grp_valid_i = 1'b1;
        cycle();
        rand_group(); clear_i = 1'b1; start_i = 1'b1; group_cnt_i = 17'd5;
        cycle();
        clear_i = 1'b0; start_i = 1'b0; grp_valid_i = 1'b0;
        chk("R9 clear result", result_o, 0);
        chk("R9 clear busy", busy_o, 0);
        chk("R9 no done", done_o, 0);
        cycle();
        chk("R9 no late done", done_o, 0);

        // R3 wrap: 70000 groups of (-128)*(-128)*2
        begin_job(70000);
        sval_i = 16'h8080; sidx_i = {2'd1, 2'd0}; dense_i = 32'h80808080;
        grp_valid_i = 1'b1;
        repeat (70000) cycle();
        grp_valid_i = 1'b0;
        exp = 64'd70000 * 64'd32768;
        chk("R3 wrap done", done_o, 1);
        chk("R3 wrapped value", s32(result_o), s32(exp));
    endtask

    initial begin
        seed_v = $urandom(32'd4711);
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual hung expected finished");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule